// File: doc/BRIEF.md
# Raster timing and line-sync generator

This block produces the beam timing for a 60 Hz interlace-free video frame. It advances once per colour-clock enable pulse, tracks the colour-clock position within a line and the line within a frame, and decodes horizontal blank, vertical blank and vertical sync from them. A readable vertical counter gives the current line number halved, which is what software polls to find where the beam is. A mode input stretches the frame from 262 to 312 lines for 50 Hz sets, with the added lines placed at the front of vertical blank so the visible region stays put.

The block also holds the horizontal-sync wait latch. When the CPU writes to the strobe address, the latch sets and pulls the CPU ready line low. It clears itself on the colour-clock edge where the next horizontal blank starts, so code resumes at a fixed point of the line.

Top module: `raster_timing_gen`

## Requirements
- R1: A line is 228 enabled colour clocks (positions 0 to 227); `hblank_o` is 1 for positions 0 to 39 and 0 for positions 40 to 227.
- R2: With `pal_i` = 0 a frame is 262 lines; after position 227 of line 261 the position returns to line 0, position 0.
- R3: `vcount_o` equals the current line number shifted right by one; it spans 0 to 130 with `pal_i` = 0 and 0 to 155 with `pal_i` = 1.
- R4: `vsync_o` is 1 on exactly six lines: lines 250 to 255 (`vcount_o` 0x7D to 0x7F) with `pal_i` = 0, lines 300 to 305 (`vcount_o` 150 to 152) with `pal_i` = 1.
- R5: With `pal_i` = 0, `vblank_o` is 1 on lines 250 to 261 and 0 to 9 (22 lines: the six sync lines then 16 more) and 0 on lines 10 to 249.
- R6: With `pal_i` = 1 the frame is 312 lines; the 50 extra lines (250 to 299) come before vertical sync and are blanked, so `vblank_o` is 1 on lines 250 to 311 and 0 to 9.
- R7: A one-clock pulse on `wsync_wr_i` drives `ready_o` to 0 from the next clock edge; it returns to 1 at the enabled edge where the position goes from 227 to 0 (start of horizontal blank).
- R8: A strobe written while horizontal blank is already active, or on the very edge where horizontal blank starts, keeps `ready_o` at 0 until the start of the following horizontal blank.
- R9: Position, `hblank_o`, `vblank_o`, `vsync_o` and `vcount_o` change only on clock edges with `cc_en_i` = 1; with `cc_en_i` = 0 they hold and no colour clock is lost.
- R10: Reset (`rst_ni` = 0) sets line 0, position 0: `hblank_o` = 1, `vblank_o` = 1, `vsync_o` = 0, `vcount_o` = 0, `ready_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cc_en_i | input | 1 | Colour-clock enable, one pulse per colour clock |
| pal_i | input | 1 | 1 selects the 312-line frame |
| wsync_wr_i | input | 1 | CPU write strobe to the sync-wait address |
| hblank_o | output | 1 | Horizontal blank |
| vblank_o | output | 1 | Vertical blank |
| vsync_o | output | 1 | Vertical sync |
| vcount_o | output | 8 | Current line number divided by two |
| ready_o | output | 1 | CPU ready, 0 while the sync-wait latch is set |

## Verification
The properties assume `pal_i` only changes while reset is held, so the frame length is fixed between resets, and that `wsync_wr_i` is a clean synchronous strobe. The stimulus changes the mode only inside a reset, applies each write strobe as a single clock, and mixes clocks with the enable low into the run so the hold behaviour is seen against a counting reference that advances only on enabled edges.

// File: rtl/raster_pkg.sv
package raster_pkg;
  localparam int unsigned LINE_CLKS_DEF   = 228;
  localparam int unsigned HBLANK_CLKS_DEF = 40;
  localparam int unsigned NTSC_LINES_DEF  = 262;
  localparam int unsigned PAL_LINES_DEF   = 312;
  localparam int unsigned VSYNC_LINES_DEF = 6;
  localparam int unsigned POST_SYNC_DEF   = 16;
  localparam int unsigned TOP_BLANK_DEF   = 10;

  typedef struct packed {
    logic vblank;
    logic vsync;
  } vdec_t;
endpackage

// File: rtl/raster_hcount.sv
module raster_hcount #(
  parameter int unsigned LINE_CLKS   = 228,
  parameter int unsigned HBLANK_CLKS = 40,
  parameter int unsigned HW          = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cc_en_i,
  output logic [HW-1:0] h_cnt_o,
  output logic          line_end_o,
  output logic          hblank_o
);
  logic [HW-1:0] h_q, h_nxt;
  logic          last;

  assign last       = (h_q == HW'(LINE_CLKS - 1));
  assign h_nxt      = last ? '0 : h_q + 1'b1;
  assign line_end_o = cc_en_i & last;
  assign h_cnt_o    = h_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_q      <= '0;
      hblank_o <= 1'b1;
    end else if (cc_en_i) begin
      h_q      <= h_nxt;
      hblank_o <= (h_nxt < HW'(HBLANK_CLKS));
    end
  end
endmodule

// File: rtl/raster_vcount.sv
module raster_vcount
  import raster_pkg::*;
#(
  parameter int unsigned NTSC_LINES  = 262,
  parameter int unsigned PAL_LINES   = 312,
  parameter int unsigned VSYNC_LINES = 6,
  parameter int unsigned POST_SYNC   = 16,
  parameter int unsigned TOP_BLANK   = 10,
  parameter int unsigned VW          = 9
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          line_end_i,
  input  logic          pal_i,
  output logic [VW-1:0] v_cnt_o,
  output logic          vblank_o,
  output logic          vsync_o,
  output logic [VW-2:0] vcount_o
);
  // lines of blank after sync that fall before the wrap
  localparam int unsigned TAIL_LINES = POST_SYNC - TOP_BLANK;
  localparam int unsigned VS_NTSC    = NTSC_LINES - TAIL_LINES - VSYNC_LINES;
  localparam int unsigned VS_PAL     = PAL_LINES - TAIL_LINES - VSYNC_LINES;
  // extra PAL lines sit ahead of sync, so blank starts at the NTSC sync line
  localparam int unsigned VBL_START  = VS_NTSC;

  logic [VW-1:0] v_q, v_nxt, last_line, vs_start;
  vdec_t         dec;

  assign last_line = pal_i ? VW'(PAL_LINES - 1) : VW'(NTSC_LINES - 1);
  assign vs_start  = pal_i ? VW'(VS_PAL) : VW'(VS_NTSC);
  assign v_nxt     = (v_q >= last_line) ? '0 : v_q + 1'b1;

  always_comb begin
    dec.vblank = (v_nxt >= VW'(VBL_START)) || (v_nxt < VW'(TOP_BLANK));
    dec.vsync  = (v_nxt >= vs_start) && (v_nxt < vs_start + VW'(VSYNC_LINES));
  end

  assign v_cnt_o = v_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q      <= '0;
      vblank_o <= 1'b1;
      vsync_o  <= 1'b0;
      vcount_o <= '0;
    end else if (line_end_i) begin
      v_q      <= v_nxt;
      vblank_o <= dec.vblank;
      vsync_o  <= dec.vsync;
      vcount_o <= v_nxt[VW-1:1];
    end
  end
endmodule

// File: rtl/raster_wsync_latch.sv
module raster_wsync_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic ready_o
);
  logic wait_q;

  // set wins over a clear on the same edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    wait_q <= 1'b0;
    else if (set_i) wait_q <= 1'b1;
    else if (clr_i) wait_q <= 1'b0;
  end

  assign ready_o = ~wait_q;
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int unsigned LINE_CLKS   = LINE_CLKS_DEF,
  parameter int unsigned HBLANK_CLKS = HBLANK_CLKS_DEF,
  parameter int unsigned NTSC_LINES  = NTSC_LINES_DEF,
  parameter int unsigned PAL_LINES   = PAL_LINES_DEF,
  parameter int unsigned VSYNC_LINES = VSYNC_LINES_DEF,
  parameter int unsigned POST_SYNC   = POST_SYNC_DEF,
  parameter int unsigned TOP_BLANK   = TOP_BLANK_DEF,
  parameter int unsigned HW          = $clog2(LINE_CLKS),
  parameter int unsigned VW          = $clog2(PAL_LINES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cc_en_i,
  input  logic          pal_i,
  input  logic          wsync_wr_i,
  output logic          hblank_o,
  output logic          vblank_o,
  output logic          vsync_o,
  output logic [VW-2:0] vcount_o,
  output logic          ready_o
);
  logic [HW-1:0] h_cnt;
  logic [VW-1:0] v_cnt;
  logic          line_end;

  raster_hcount #(
    .LINE_CLKS  (LINE_CLKS),
    .HBLANK_CLKS(HBLANK_CLKS),
    .HW         (HW)
  ) i_hcount (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cc_en_i   (cc_en_i),
    .h_cnt_o   (h_cnt),
    .line_end_o(line_end),
    .hblank_o  (hblank_o)
  );

  raster_vcount #(
    .NTSC_LINES (NTSC_LINES),
    .PAL_LINES  (PAL_LINES),
    .VSYNC_LINES(VSYNC_LINES),
    .POST_SYNC  (POST_SYNC),
    .TOP_BLANK  (TOP_BLANK),
    .VW         (VW)
  ) i_vcount (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .line_end_i(line_end),
    .pal_i     (pal_i),
    .v_cnt_o   (v_cnt),
    .vblank_o  (vblank_o),
    .vsync_o   (vsync_o),
    .vcount_o  (vcount_o)
  );

  // line end is the edge where the next horizontal blank begins
  raster_wsync_latch i_wsync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wsync_wr_i),
    .clr_i  (line_end),
    .ready_o(ready_o)
  );
endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
  parameter int unsigned LINE_CLKS   = 228,
  parameter int unsigned HBLANK_CLKS = 40,
  parameter int unsigned NTSC_LINES  = 262,
  parameter int unsigned PAL_LINES   = 312,
  parameter int unsigned HW          = 8,
  parameter int unsigned VW          = 9
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cc_en_i,
  input logic          pal_i,
  input logic          wsync_wr_i,
  input logic          hblank_o,
  input logic          vblank_o,
  input logic          vsync_o,
  input logic [VW-2:0] vcount_o,
  input logic          ready_o,
  input logic [HW-1:0] h_cnt,
  input logic [VW-1:0] v_cnt
);
  // R1
  hblank_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_en_i && h_cnt == HW'(HBLANK_CLKS - 1)) |=> !hblank_o);

  // R1
  hblank_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cc_en_i && h_cnt == HW'(LINE_CLKS - 1)) |=> hblank_o);

  // R2
  line_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    v_cnt < (pal_i ? VW'(PAL_LINES) : VW'(NTSC_LINES)));

  // R3
  vcount_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vcount_o <= (pal_i ? (VW-1)'(PAL_LINES/2 - 1) : (VW-1)'(NTSC_LINES/2 - 1)));

  // R4
  vsync_in_vblank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsync_o |-> vblank_o);

  // R7
  wsync_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wsync_wr_i |=> !ready_o);

  // R7
  wsync_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && cc_en_i && h_cnt == HW'(LINE_CLKS - 1) && !wsync_wr_i) |=> ready_o);

  // R8
  wsync_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !(cc_en_i && h_cnt == HW'(LINE_CLKS - 1))) |=> !ready_o);

  // R9
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cc_en_i && !wsync_wr_i) |=> ($stable(hblank_o) && $stable(vblank_o) &&
      $stable(vsync_o) && $stable(vcount_o) && $stable(ready_o)));
endmodule

bind raster_timing_gen raster_timing_chk #(
  .LINE_CLKS  (LINE_CLKS),
  .HBLANK_CLKS(HBLANK_CLKS),
  .NTSC_LINES (NTSC_LINES),
  .PAL_LINES  (PAL_LINES),
  .HW         (HW),
  .VW         (VW)
) i_raster_timing_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .cc_en_i   (cc_en_i),
  .pal_i     (pal_i),
  .wsync_wr_i(wsync_wr_i),
  .hblank_o  (hblank_o),
  .vblank_o  (vblank_o),
  .vsync_o   (vsync_o),
  .vcount_o  (vcount_o),
  .ready_o   (ready_o),
  .h_cnt     (h_cnt),
  .v_cnt     (v_cnt)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;
  localparam int CLK_PERIOD = 10;
  localparam int LINE_CLKS  = 228;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cc_en = 1'b0;
  logic       pal = 1'b0;
  logic       wsync_wr = 1'b0;
  logic       hblank, vblank, vsync, ready;
  logic [7:0] vcount;

  int checks = 0;
  int failures = 0;
  int cur_line = 0;
  int cur_h = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .cc_en_i   (cc_en),
    .pal_i     (pal),
    .wsync_wr_i(wsync_wr),
    .hblank_o  (hblank),
    .vblank_o  (vblank),
    .vsync_o   (vsync),
    .vcount_o  (vcount),
    .ready_o   (ready)
  );

  typedef struct packed {
    logic       pal;
    logic [9:0] line;   // absolute line since reset
    logic [7:0] hpos;
    logic       hb;
    logic       vb;
    logic       vs;
    logic [7:0] vc;
  } vec_t;

  localparam int NVEC = 24;
  localparam vec_t TBL [NVEC] = '{
    '{1'b0, 10'd0,   8'd39,  1'b1, 1'b1, 1'b0, 8'd0},
    '{1'b0, 10'd0,   8'd40,  1'b0, 1'b1, 1'b0, 8'd0},
    '{1'b0, 10'd9,   8'd100, 1'b0, 1'b1, 1'b0, 8'd4},
    '{1'b0, 10'd10,  8'd100, 1'b0, 1'b0, 1'b0, 8'd5},
    '{1'b0, 10'd10,  8'd227, 1'b0, 1'b0, 1'b0, 8'd5},
    '{1'b0, 10'd11,  8'd0,   1'b1, 1'b0, 1'b0, 8'd5},
    '{1'b0, 10'd130, 8'd50,  1'b0, 1'b0, 1'b0, 8'd65},
    '{1'b0, 10'd249, 8'd227, 1'b0, 1'b0, 1'b0, 8'd124},
    '{1'b0, 10'd250, 8'd0,   1'b1, 1'b1, 1'b1, 8'd125},
    '{1'b0, 10'd255, 8'd200, 1'b0, 1'b1, 1'b1, 8'd127},
    '{1'b0, 10'd256, 8'd0,   1'b1, 1'b1, 1'b0, 8'd128},
    '{1'b0, 10'd261, 8'd227, 1'b0, 1'b1, 1'b0, 8'd130},
    '{1'b0, 10'd262, 8'd0,   1'b1, 1'b1, 1'b0, 8'd0},
    '{1'b1, 10'd249, 8'd100, 1'b0, 1'b0, 1'b0, 8'd124},
    '{1'b1, 10'd250, 8'd0,   1'b1, 1'b1, 1'b0, 8'd125},
    '{1'b1, 10'd261, 8'd227, 1'b0, 1'b1, 1'b0, 8'd130},
    '{1'b1, 10'd262, 8'd0,   1'b1, 1'b1, 1'b0, 8'd131},
    '{1'b1, 10'd299, 8'd227, 1'b0, 1'b1, 1'b0, 8'd149},
    '{1'b1, 10'd300, 8'd0,   1'b1, 1'b1, 1'b1, 8'd150},
    '{1'b1, 10'd305, 8'd227, 1'b0, 1'b1, 1'b1, 8'd152},
    '{1'b1, 10'd306, 8'd0,   1'b1, 1'b1, 1'b0, 8'd153},
    '{1'b1, 10'd311, 8'd227, 1'b0, 1'b1, 1'b0, 8'd155},
    '{1'b1, 10'd312, 8'd0,   1'b1, 1'b1, 1'b0, 8'd0},
    '{1'b1, 10'd322, 8'd0,   1'b1, 1'b0, 1'b0, 8'd5}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s line=%0d hpos=%0d actual=%0d expected=%0d",
               req, what, cur_line, cur_h, act, exp);
    end
  endtask

  // one clock: inputs driven after a negedge, result sampled at the next negedge
  task automatic step(input bit en, input bit wr);
    cc_en    = en;
    wsync_wr = wr;
    @(negedge clk);
    cc_en    = 1'b0;
    wsync_wr = 1'b0;
    if (en) begin
      cur_h++;
      if (cur_h == LINE_CLKS) begin
        cur_h = 0;
        cur_line++;
      end
    end
  endtask

  task automatic advance_to(input int l, input int h);
    while (cur_line != l || cur_h != h) step(1'b1, 1'b0);
  endtask

  task automatic do_reset(input bit p);
    rst_n = 1'b0;
    pal   = p;
    cc_en = 1'b0;
    wsync_wr = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_line = 0;
    cur_h = 0;
    @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    check("R10", {tag, " hblank"}, int'(hblank), 1);
    check("R10", {tag, " vblank"}, int'(vblank), 1);
    check("R10", {tag, " vsync"},  int'(vsync), 0);
    check("R10", {tag, " vcount"}, int'(vcount), 0);
    check("R10", {tag, " ready"},  int'(ready), 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired line=%0d hpos=%0d actual=running expected=done",
             cur_line, cur_h);
    finish_run();
  end

  initial begin
    @(negedge clk);
    do_reset(1'b0);
    check_reset_state("after reset");

    // table walk; a mode change forces a reset
    for (int i = 0; i < NVEC; i++) begin
      if (TBL[i].pal != pal) do_reset(TBL[i].pal);
      advance_to(int'(TBL[i].line), int'(TBL[i].hpos));
      check("R1", "hblank", int'(hblank), int'(TBL[i].hb));
      check(pal ? "R6" : "R5", "vblank", int'(vblank), int'(TBL[i].vb));
      check("R4", "vsync", int'(vsync), int'(TBL[i].vs));
      if (!pal && TBL[i].line >= 10'd262)
        check("R2", "vcount after wrap", int'(vcount), int'(TBL[i].vc));
      else
        check("R3", "vcount", int'(vcount), int'(TBL[i].vc));
      if (pal && TBL[i].line >= 10'd312)
        check("R6", "frame wrap vcount", int'(vcount), int'(TBL[i].vc));
    end

    // sync-wait latch, NTSC, frame 2 lines 1..
    do_reset(1'b0);
    advance_to(1, 100);
    step(1'b0, 1'b1);
    check("R7", "ready after write", int'(ready), 0);
    advance_to(1, 227);
    check("R7", "ready before hblank", int'(ready), 0);
    step(1'b1, 1'b0);
    check("R7", "ready at hblank start", int'(ready), 1);

    advance_to(2, 10);
    step(1'b0, 1'b1);
    check("R8", "ready write in hblank", int'(ready), 0);
    advance_to(2, 39);
    check("R8", "ready end of this hblank", int'(ready), 0);
    advance_to(2, 227);
    check("R8", "ready line end", int'(ready), 0);
    step(1'b1, 1'b0);
    check("R8", "ready next hblank", int'(ready), 1);

    advance_to(3, 227);
    step(1'b1, 1'b1);
    check("R8", "ready write on hblank edge", int'(ready), 0);
    advance_to(4, 227);
    check("R8", "ready held through line", int'(ready), 0);
    step(1'b1, 1'b0);
    check("R8", "ready after following hblank", int'(ready), 1);

    // enable gaps
    advance_to(5, 50);
    repeat (20) step(1'b0, 1'b0);
    check("R9", "hblank held", int'(hblank), 0);
    check("R9", "vcount held", int'(vcount), 2);
    advance_to(5, 227);
    check("R9", "hblank before edge", int'(hblank), 0);
    repeat (5) step(1'b0, 1'b0);
    check("R9", "hblank no early edge", int'(hblank), 0);
    step(1'b1, 1'b0);
    check("R9", "hblank after gap", int'(hblank), 1);
    check("R9", "vcount after gap", int'(vcount), 3);

    // asynchronous reset mid-line with the latch set
    advance_to(20, 120);
    step(1'b0, 1'b1);
    check("R7", "ready before reset", int'(ready), 0);
    rst_n = 1'b0;
    #1;
    check_reset_state("mid-run reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_line = 0;
    cur_h = 0;
    check_reset_state("after release");

    finish_run();
  end
endmodule